// File: doc/BRIEF.md
# G3RUH Line Coder (9600 baud scrambler, descrambler and differential coding)

This block performs the line coding for a 9600 baud FSK radio modem. The modem supplies the bit clock and exchanges bits with the host side in bursts of 16. On the transmit side the block takes 16-bit words from the framing layer and sends them out one bit per bit strobe, least significant bit first. Each bit goes through a self-synchronising x^17 + x^12 + 1 scrambler and then through differential (transition) coding before it reaches the line. On the receive side the block takes one line bit per receive strobe and undoes both stages in a single pass over an 18-bit history of past line bits. It collects the recovered bits least significant bit first into 16-bit words for the framing layer.

Transmit and receive are independent: each has its own bit strobe and its own word counter. The receiver needs no knowledge of the transmitter's state. Once its history holds 18 genuine line bits, it tracks any transmitter regardless of that transmitter's starting state. HDLC framing and bit stuffing belong to the layer above.

Top module: `g3ruh_line_coder`

## Requirements
- R1: After reset, txLine is 0, rxValid is 0, rxWord is 0 and txReady is 1. The scrambler history and the receive history are all zero.
- R2: txReady is 1 exactly when the next transmit strobe starts a new word. txWord is sampled only on the clock where txBitEn and txReady are both 1. txReady then stays 0 for the following 15 strobes, and txWord is ignored during them.
- R3: Each txBitEn strobe sends one data bit, least significant bit first. txLine changes only on the clock edge that samples a strobe.
- R4: For data bit d_n, the scrambled bit is c_n = NOT d_n XOR c_(n-12) XOR c_(n-17), where c_(n-k) is the scrambled bit k strobes earlier.
- R5: Differential coding gives txLine_n = txLine_(n-1) XOR c_n, so a scrambled 1 toggles the line and a scrambled 0 holds it.
- R6: On each rxBitEn strobe the receiver forms e_n = rxLine XOR (previous line bit). The data bit is NOT (e_n XOR e_(n-12) XOR e_(n-17)), taken from an 18-bit history of previous line bits. That history is then shifted and the new line bit is placed at its bottom.
- R7: Received bits fill the word least significant bit first. On the clock after every 16th receive strobe, rxValid is 1 for exactly one cycle and rxWord shows the new word. rxWord holds its value at all other times.
- R8: The receiver can start against a transmitter that has an arbitrary scrambler history. Every word whose bits all have 18 genuine line bits of history before them then decodes to the transmitted data.
- R9: A receiver fed, from reset, the line stream of a transmitter that also starts from reset reproduces every word exactly, starting with the first.
- R10: While its strobe is 0, a path ignores its inputs: rxLine does not affect the receiver and txWord does not affect the transmitter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txBitEn | input | 1 | Transmit bit strobe from the modem, one clock per line bit |
| txWord | input | 16 | Word to transmit, sampled when txReady and txBitEn are 1 |
| txReady | output | 1 | The next transmit strobe will take txWord |
| txLine | output | 1 | Coded transmit line bit |
| rxBitEn | input | 1 | Receive bit strobe from the modem |
| rxLine | input | 1 | Coded receive line bit, sampled on rxBitEn |
| rxWord | output | 16 | Last recovered word |
| rxValid | output | 1 | One-cycle pulse when rxWord has been updated |

## Verification
The embedded properties check the framing of the two paths on every cycle. txLine and the receive history move only on a strobe. Each transmit step records in the scrambler history exactly the transition it puts on the line. txReady drops after a word is taken, and rxWord changes only under a single-cycle rxValid. The scrambling equation itself, the least-significant-first bit order, the decoded values, and self-synchronisation after a mismatched start can only be shown by the bench scenarios. In those, the bench compares the coded bit stream and the recovered words with its own model of the equations, and with the original data for loopback and resynchronisation.

// File: rtl/g3ruh_pkg.sv
package g3ruh_pkg;

  // Default geometry of the line code
  localparam int unsigned DEF_WORD_W   = 16;
  localparam int unsigned DEF_TAP_NEAR = 12;
  localparam int unsigned DEF_TAP_FAR  = 17;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic txLoad;   // take a fresh word on this transmit step
    logic txStep;   // advance transmit scrambler by one bit
    logic rxStep;   // advance receive history by one bit
    logic rxDone;   // this receive step completes a word
  } coderCtl_t;

endpackage

// File: rtl/g3ruh_ctrl.sv
module g3ruh_ctrl
  import g3ruh_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txBitEn,
  input  logic      rxBitEn,
  output logic      txReady,
  output coderCtl_t ctl
);

  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] rxCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt <= '0;
    end else if (txBitEn) begin
      txCnt <= (txCnt == LAST_BIT) ? '0 : txCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt <= '0;
    end else if (rxBitEn) begin
      rxCnt <= (rxCnt == LAST_BIT) ? '0 : rxCnt + 1'b1;
    end
  end

  assign txReady = (txCnt == '0);

  always_comb begin
    ctl        = '0;
    ctl.txStep = txBitEn;
    ctl.txLoad = txBitEn && txReady;
    ctl.rxStep = rxBitEn;
    ctl.rxDone = rxBitEn && (rxCnt == LAST_BIT);
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (txBitEn && txReady) |=> !txReady); // R2

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !txBitEn |=> $stable(txReady)); // R2

endmodule

// File: rtl/g3ruh_datapath.sv
module g3ruh_datapath
  import g3ruh_pkg::*;
#(
  parameter int unsigned WORD_W   = DEF_WORD_W,
  parameter int unsigned TAP_NEAR = DEF_TAP_NEAR,
  parameter int unsigned TAP_FAR  = DEF_TAP_FAR
) (
  input  logic              clk,
  input  logic              rstN,
  input  coderCtl_t         ctl,
  input  logic [WORD_W-1:0] txWord,
  output logic              txLine,
  input  logic              rxLine,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);

  // Receive history spans one bit beyond the far tap so that the
  // transition at that tap can be formed.
  localparam int unsigned HIST_W = TAP_FAR + 1;

  // ---------------- transmit: serialise, scramble, transition-code
  logic [WORD_W-1:0]  txBuf;
  logic [TAP_FAR-1:0] txHist;   // txHist[k] = scrambled bit k+1 steps ago
  logic               dataBit;
  logic               scrBit;

  assign dataBit = ctl.txLoad ? txWord[0] : txBuf[0];
  assign scrBit  = ~dataBit ^ txHist[TAP_NEAR-1] ^ txHist[TAP_FAR-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf  <= '0;
      txHist <= '0;
      txLine <= 1'b0;
    end else if (ctl.txStep) begin
      txBuf  <= ctl.txLoad ? (txWord >> 1) : (txBuf >> 1);
      txHist <= {txHist[TAP_FAR-2:0], scrBit};
      txLine <= txLine ^ scrBit;
    end
  end

  // ---------------- receive: fused transition decode and descramble
  logic [HIST_W-1:0] rxHist;    // rxHist[k] = line bit k+1 steps ago
  logic [WORD_W-1:0] rxAcc;
  logic              edgeNow;
  logic              edgeNear;
  logic              edgeFar;
  logic              rxBit;

  assign edgeNow  = rxLine ^ rxHist[0];
  assign edgeNear = rxHist[TAP_NEAR-1] ^ rxHist[TAP_NEAR];
  assign edgeFar  = rxHist[TAP_FAR-1] ^ rxHist[TAP_FAR];
  assign rxBit    = ~(edgeNow ^ edgeNear ^ edgeFar);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHist  <= '0;
      rxAcc   <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= ctl.rxDone;
      if (ctl.rxStep) begin
        rxHist <= {rxHist[HIST_W-2:0], rxLine};
        rxAcc  <= {rxBit, rxAcc[WORD_W-1:1]};
      end
      if (ctl.rxDone) begin
        rxWord <= {rxBit, rxAcc[WORD_W-1:1]};
      end
    end
  end

  AST_TX_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.txStep |=> $stable(txLine)); // R3

  AST_TX_DIFF_CODE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txStep |=> (txHist[0] == (txLine ^ $past(txLine)))); // R5

  AST_RX_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rxStep |=> $stable(rxHist)); // R10

  AST_RX_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxWord)); // R7

  AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R7

endmodule

// File: rtl/g3ruh_line_coder.sv
module g3ruh_line_coder
  import g3ruh_pkg::*;
#(
  parameter int unsigned WORD_W   = DEF_WORD_W,
  parameter int unsigned TAP_NEAR = DEF_TAP_NEAR,
  parameter int unsigned TAP_FAR  = DEF_TAP_FAR
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBitEn,
  input  logic [WORD_W-1:0] txWord,
  output logic              txReady,
  output logic              txLine,
  input  logic              rxBitEn,
  input  logic              rxLine,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);

  coderCtl_t ctl;

  g3ruh_ctrl #(
    .WORD_W (WORD_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .txBitEn (txBitEn),
    .rxBitEn (rxBitEn),
    .txReady (txReady),
    .ctl     (ctl)
  );

  g3ruh_datapath #(
    .WORD_W   (WORD_W),
    .TAP_NEAR (TAP_NEAR),
    .TAP_FAR  (TAP_FAR)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .txWord  (txWord),
    .txLine  (txLine),
    .rxLine  (rxLine),
    .rxWord  (rxWord),
    .rxValid (rxValid)
  );

endmodule

// File: tb/tb_g3ruh_line_coder.sv
`timescale 1ns/1ps
module tb_g3ruh_line_coder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txBitEn = 1'b0;
  logic [15:0] txWord = '0;
  logic        txReady;
  logic        txLine;
  logic        rxBitEn;
  logic        rxLine;
  logic [15:0] rxWord;
  logic        rxValid;

  logic loopMode = 1'b0;
  logic rxDrv = 1'b0;
  logic rxEnDrv = 1'b0;

  assign rxBitEn = loopMode ? txBitEn : rxEnDrv;
  assign rxLine  = loopMode ? txLine  : rxDrv;

  always #5 clk = ~clk;

  g3ruh_line_coder dut (
    .clk     (clk),
    .rstN    (rstN),
    .txBitEn (txBitEn),
    .txWord  (txWord),
    .txReady (txReady),
    .txLine  (txLine),
    .rxBitEn (rxBitEn),
    .rxLine  (rxLine),
    .rxWord  (rxWord),
    .rxValid (rxValid)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // scoreboard queues
  logic        txQ[$];
  logic [15:0] rxQ[$];
  string       rxTagQ[$];

  // encoder model A (drives expectations of txLine)
  logic [16:0] aHist;
  logic        aLine;
  // encoder model B (builds receive stimulus)
  logic [16:0] bHist;
  logic        bLine;
  // decoder model
  logic [17:0] dH;
  logic [15:0] dAcc;
  int          dCnt;
  logic [15:0] dWord;
  bit          dDone;

  task automatic encA(input logic d);
    logic c;
    c = ~d ^ aHist[11] ^ aHist[16];        // R4
    aHist = {aHist[15:0], c};
    aLine = aLine ^ c;                     // R5
  endtask

  task automatic encB(input logic d);
    logic c;
    c = ~d ^ bHist[11] ^ bHist[16];
    bHist = {bHist[15:0], c};
    bLine = bLine ^ c;
  endtask

  task automatic decStep(input logic l);
    logic e0, e12, e17, b;
    e0  = l ^ dH[0];
    e12 = dH[11] ^ dH[12];
    e17 = dH[16] ^ dH[17];
    b   = ~(e0 ^ e12 ^ e17);               // R6
    dH   = {dH[16:0], l};
    dAcc = {b, dAcc[15:1]};
    dCnt++;
    dDone = 0;
    if (dCnt == 16) begin
      dCnt  = 0;
      dWord = dAcc;
      dDone = 1;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: strobe tracking and comparison away from the active edge
  logic txSeen = 1'b0;
  logic rxSeen = 1'b0;
  always @(posedge clk) begin
    txSeen <= txBitEn;
    rxSeen <= rxBitEn;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (txSeen) begin
        if (txQ.size() == 0) begin
          check(0, "R3", "txLine step with no expectation", 16'(txLine), 0);
        end else begin
          logic e;
          e = txQ.pop_front();
          check(txLine == e, "R3/R4/R5", "txLine", 16'(txLine), 16'(e));
        end
      end
      if (rxValid) begin
        check(rxSeen, "R7", "rxValid without preceding strobe", 16'(rxSeen), 1);
        if (rxQ.size() == 0) begin
          check(0, "R7", "unexpected rxValid", rxWord, 0);
        end else begin
          logic [15:0] w;
          string t;
          w = rxQ.pop_front();
          t = rxTagQ.pop_front();
          check(rxWord == w, t, "rxWord", rxWord, w);
        end
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    txBitEn = 1'b0;
    rxEnDrv = 1'b0;
    aHist = '0; aLine = 1'b0;
    bHist = '0; bLine = 1'b0;
    dH = '0; dAcc = '0; dCnt = 0; dDone = 0; dWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // transmit driver; in loop mode also feeds the decoder model
  task automatic txSend(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      check(txReady == (i == 0), "R2", "txReady", 16'(txReady), 16'(i == 0));
      txWord = (i == 0) ? w : 16'($urandom);  // R10: ignored mid-word
      if (loopMode) begin
        decStep(aLine);
        if (dDone) begin
          rxQ.push_back(dWord);
          rxTagQ.push_back("R6/R7");
        end
      end
      encA(w[i]);
      txQ.push_back(aLine);
      txBitEn = 1'b1;
      @(negedge clk);
      txBitEn = 1'b0;
      txWord = 16'($urandom);
      repeat (2) @(negedge clk);
    end
  endtask

  // receive driver from encoder model B
  task automatic rxSend(input logic [15:0] w, input bit useModel, input string tag);
    for (int i = 0; i < 16; i++) begin
      logic l;
      encB(w[i]);
      l = bLine;
      decStep(l);
      if (dDone) begin
        rxQ.push_back(useModel ? dWord : w);
        rxTagQ.push_back(tag);
      end
      rxDrv = l;
      rxEnDrv = 1'b1;
      @(negedge clk);
      rxEnDrv = 1'b0;
      rxDrv = ~l;                           // R10: toggles between strobes
      @(negedge clk);
      rxDrv = l;
      @(negedge clk);
      rxDrv = ~l;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check(txLine == 1'b0, "R1", "txLine after reset", 16'(txLine), 0);
    check(rxValid == 1'b0, "R1", "rxValid after reset", 16'(rxValid), 0);
    check(rxWord == 16'h0, "R1", "rxWord after reset", rxWord, 0);
    check(txReady == 1'b1, "R1", "txReady after reset", 16'(txReady), 1);

    // loopback: transmit stream checked bit by bit, receiver against model
    loopMode = 1'b1;
    txSend(16'h0000);
    txSend(16'hFFFF);
    txSend(16'hA5C3);
    txSend(16'h8001);
    for (int k = 0; k < 4; k++) txSend(16'($urandom));
    repeat (4) @(negedge clk);
    loopMode = 1'b0;

    // aligned from reset: exact words (R9)
    doReset();
    rxSend(16'h1234, 0, "R9");
    rxSend(16'hFFFF, 0, "R9");
    rxSend(16'h0000, 0, "R9");
    rxSend(16'h5A5A, 0, "R9");
    rxSend(16'h8001, 0, "R9");

    // transmitter with a foreign history: resynchronisation (R8)
    doReset();
    bHist = 17'h1A5C3;
    bLine = 1'b1;
    rxSend(16'hC0DE, 1, "R6");
    rxSend(16'h7E7E, 1, "R6");
    rxSend(16'hBEEF, 0, "R8");
    rxSend(16'h0F0F, 0, "R8");
    rxSend(16'h1357, 0, "R8");
    rxSend(16'hFFFE, 0, "R8");

    repeat (4) @(negedge clk);
    check(txQ.size() == 0, "R3", "pending transmit bits", 16'(txQ.size()), 0);
    check(rxQ.size() == 0, "R7", "pending receive words", 16'(rxQ.size()), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule